// File: doc/BRIEF.md
# Keyed Sequence Pattern Detector

The block watches a stream of fixed-size 128-bit records. Each record carries a partition key and a price, and the block looks for a three-step event pattern inside each partition separately. Every record is first sorted into one of three event classes by comparing its price with a pivot value:

- price equal to the pivot starts a candidate match;
- price above the pivot extends a candidate;
- price below the pivot completes a candidate.

A match is an opener, then any number of extenders (zero included), then a closer, all from the same partition. When a partition completes the pattern, the block gives a one-cycle notification carrying that partition's key.

Partition state is not held in one global automaton. It sits in a small table indexed by a hash of the key, and each entry stores a tag so that key collisions can be detected. For every record, the entry is read, stepped and written back. A pipeline bypass keeps updates to the same entry on consecutive cycles correct. The block takes one record on every clock cycle. A new partition that finds its slot held by another live partition is dropped, and a drop counter records it.

Top module: `keyed_pattern_detector`

## Requirements
- R1: While reset is high, and on the first cycle after it falls, `match_valid` is 0 and `drop_count` is 0, and every partition is idle.
- R2: `in_ready` is 1 on every cycle out of reset, and a record offered with `in_valid` high is taken on every such cycle.
- R3: The key is `in_record[31:0]`. The price is the unsigned field `in_record[63:32]`. Price equal to 20 is an opener, above 20 (up to all ones) an extender, and below 20 a closer; all other record bits are ignored.
- R4: A partition that receives an opener, zero or more extenders, then a closer raises `match_valid` for exactly one cycle, with `match_key` equal to that key. The pulse appears on the second rising edge after the edge that takes the closer.
- R5: An opener always restarts the partition's candidate, even if one is already open. Opener, extender, opener, closer therefore gives exactly one match, at the closer.
- R6: An extender or closer for a partition with no open candidate has no effect. After a match the partition is idle again.
- R7: Partitions are independent: interleaving records of keys in different slots gives the same matches as feeding each key alone.
- R8: Records for the same key, or for keys sharing a slot, on back-to-back cycles lose no update.
- R9: The slot of a key is the XOR of its eight 4-bit nibbles. An opener whose slot holds an open candidate of a different key is dropped: `drop_count` rises by 1 on the same cycle a match would appear, and the holder's candidate is unchanged.
- R10: A slot is freed when its partition returns to idle through a match. A different key may then claim it, on the very next cycle included.
- R11: A cycle with `in_valid` low changes no partition, raises no match and leaves `drop_count` unchanged, whatever `in_record` holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Record on `in_record` is offered this cycle |
| in_ready | output | 1 | Block takes a record this cycle |
| in_record | input | 128 | Record: key in [31:0], unsigned price in [63:32] |
| match_valid | output | 1 | One-cycle pulse: a partition completed the pattern |
| match_key | output | 32 | Key of the completing partition, valid with `match_valid` |
| drop_count | output | 16 | Number of openers dropped on slot conflicts (wraps) |

## Verification
The timing assertions compare outputs with the input two cycles earlier. They therefore take for granted that `in_valid` stays low while reset is high and on the cycle reset falls, so that the window never reaches back into unknown input. The bench holds `in_valid` low throughout reset and drives two idle cycles after release before sending the first record. Its random phase draws keys from a small pool that includes two keys sharing slot 0, so that conflicts, slot reuse and same-slot back-to-back traffic all occur. Prices are biased toward 19, 20 and 21, with all-ones and zero mixed in.

// File: rtl/kpd_pkg.sv
package kpd_pkg;

  // Basic-event flags produced by the classifier; at most one is set.
  typedef struct packed {
    logic is_open;
    logic is_ext;
    logic is_close;
  } evt_t;

  // One-hot partition automaton state; all-zero means no open candidate.
  typedef enum logic [1:0] {
    ST_IDLE   = 2'b00,
    ST_OPENED = 2'b01,
    ST_EXTEND = 2'b10
  } nfa_st_e;

endpackage

// File: rtl/kpd_classify.sv
module kpd_classify
  import kpd_pkg::*;
#(
  parameter int REC_W     = 128,
  parameter int KEY_W     = 32,
  parameter int PRICE_W   = 32,
  parameter int PRICE_LSB = 32,
  parameter int PIVOT     = 20,
  parameter int IDX_W     = 4
) (
  input  logic [REC_W-1:0] rec,
  output logic [KEY_W-1:0] key,
  output logic [IDX_W-1:0] idx,
  output evt_t             ev
);

  localparam int NCHUNK = (KEY_W + IDX_W - 1) / IDX_W;
  localparam int PAD_W  = NCHUNK * IDX_W;

  logic [PRICE_W-1:0] price;
  logic [PAD_W-1:0]   key_pad;

  assign key   = rec[KEY_W-1:0];
  assign price = rec[PRICE_LSB +: PRICE_W];

  // Fold the key into a slot index, chunk by chunk.
  always_comb begin
    key_pad = '0;
    key_pad[KEY_W-1:0] = key;
    idx = '0;
    for (int i = 0; i < NCHUNK; i++) begin
      idx = idx ^ key_pad[i*IDX_W +: IDX_W];
    end
  end

  // All three predicates evaluated in parallel.
  always_comb begin
    ev.is_open  = (price == PRICE_W'(PIVOT));
    ev.is_ext   = (price >  PRICE_W'(PIVOT));
    ev.is_close = (price <  PRICE_W'(PIVOT));
  end

endmodule

// File: rtl/kpd_nfa_step.sv
module kpd_nfa_step
  import kpd_pkg::*;
(
  input  nfa_st_e cur,
  input  evt_t    ev,
  output nfa_st_e nxt,
  output logic    accept
);

  always_comb begin
    nxt    = cur;
    accept = 1'b0;
    if (ev.is_open) begin
      nxt = ST_OPENED;
    end else if (cur != ST_IDLE) begin
      if (ev.is_ext) begin
        nxt = ST_EXTEND;
      end else if (ev.is_close) begin
        nxt    = ST_IDLE;
        accept = 1'b1;
      end
    end
  end

endmodule

// File: rtl/kpd_state_table.sv
module kpd_state_table #(
  parameter int KEY_W = 32,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_live,
  input  logic [KEY_W-1:0] wr_tag,
  input  logic [1:0]       wr_state,
  output logic             rd_live,
  output logic [KEY_W-1:0] rd_tag,
  output logic [1:0]       rd_state
);

  localparam int DEPTH = 1 << IDX_W;
  localparam int ENT_W = KEY_W + 2;

  // Tag and state in a plain synchronous-read array (block RAM friendly);
  // liveness in flops so that reset clears every slot at once.
  logic [ENT_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0] live_q;
  logic [ENT_W-1:0] mem_q;
  logic             live_rd_q;
  logic [ENT_W-1:0] byp_q;
  logic             byp_live_q;
  logic             byp_hit_q;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_idx] <= {wr_tag, wr_state};
    end
    mem_q <= mem[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      live_q    <= '0;
      live_rd_q <= 1'b0;
      byp_hit_q <= 1'b0;
    end else begin
      if (wr_en) begin
        live_q[wr_idx] <= wr_live;
      end
      live_rd_q <= live_q[rd_idx];
      byp_hit_q <= wr_en && (wr_idx == rd_idx);
    end
  end

  // The read and the write on one edge see the old entry; keep the new one.
  always_ff @(posedge clk) begin
    byp_q      <= {wr_tag, wr_state};
    byp_live_q <= wr_live;
  end

  assign {rd_tag, rd_state} = byp_hit_q ? byp_q : mem_q;
  assign rd_live            = byp_hit_q ? byp_live_q : live_rd_q;

endmodule

// File: rtl/keyed_pattern_detector.sv
module keyed_pattern_detector
  import kpd_pkg::*;
#(
  parameter int REC_W     = 128,
  parameter int KEY_W     = 32,
  parameter int PRICE_W   = 32,
  parameter int PRICE_LSB = 32,
  parameter int PIVOT     = 20,
  parameter int IDX_W     = 4,
  parameter int CNT_W     = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [REC_W-1:0] in_record,
  output logic             match_valid,
  output logic [KEY_W-1:0] match_key,
  output logic [CNT_W-1:0] drop_count
);

  logic [KEY_W-1:0] c_key;
  logic [IDX_W-1:0] c_idx;
  evt_t             c_ev;

  logic             s1_v;
  logic [KEY_W-1:0] s1_key;
  logic [IDX_W-1:0] s1_idx;
  evt_t             s1_ev;

  logic             t_live;
  logic [KEY_W-1:0] t_tag;
  logic [1:0]       t_state;

  logic             hit;
  nfa_st_e          cur_st;
  nfa_st_e          nxt_st;
  logic             accept;

  logic             wr_en;
  logic             wr_live;
  logic [1:0]       wr_state;
  logic             drop;

  assign in_ready = 1'b1;

  kpd_classify #(
    .REC_W(REC_W), .KEY_W(KEY_W), .PRICE_W(PRICE_W),
    .PRICE_LSB(PRICE_LSB), .PIVOT(PIVOT), .IDX_W(IDX_W)
  ) u_classify (
    .rec (in_record),
    .key (c_key),
    .idx (c_idx),
    .ev  (c_ev)
  );

  // Stage 1 register: aligns the record with the table read data.
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v <= 1'b0;
    end else begin
      s1_v <= in_valid;
    end
    s1_key <= c_key;
    s1_idx <= c_idx;
    s1_ev  <= c_ev;
  end

  kpd_state_table #(
    .KEY_W(KEY_W), .IDX_W(IDX_W)
  ) u_table (
    .clk      (clk),
    .rst      (rst),
    .rd_idx   (c_idx),
    .wr_en    (wr_en),
    .wr_idx   (s1_idx),
    .wr_live  (wr_live),
    .wr_tag   (s1_key),
    .wr_state (wr_state),
    .rd_live  (t_live),
    .rd_tag   (t_tag),
    .rd_state (t_state)
  );

  assign hit    = t_live && (t_tag == s1_key);
  assign cur_st = hit ? nfa_st_e'(t_state) : ST_IDLE;

  kpd_nfa_step u_step (
    .cur    (cur_st),
    .ev     (s1_ev),
    .nxt    (nxt_st),
    .accept (accept)
  );

  // Write-back decision: claim, update, free, or drop.
  always_comb begin
    wr_en    = 1'b0;
    wr_live  = 1'b0;
    wr_state = ST_IDLE;
    drop     = 1'b0;
    if (s1_v) begin
      if (s1_ev.is_open) begin
        if (!t_live || hit) begin
          wr_en    = 1'b1;
          wr_live  = 1'b1;
          wr_state = nxt_st;
        end else begin
          drop = 1'b1;
        end
      end else if (hit) begin
        wr_en    = 1'b1;
        wr_live  = (nxt_st != ST_IDLE);
        wr_state = nxt_st;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      match_valid <= 1'b0;
      match_key   <= '0;
      drop_count  <= '0;
    end else begin
      match_valid <= s1_v && accept;
      if (s1_v && accept) begin
        match_key <= s1_key;
      end
      if (drop) begin
        drop_count <= drop_count + 1'b1;
      end
    end
  end

endmodule

// File: rtl/kpd_checker.sv
module kpd_checker #(
  parameter int REC_W     = 128,
  parameter int KEY_W     = 32,
  parameter int PRICE_W   = 32,
  parameter int PRICE_LSB = 32,
  parameter int PIVOT     = 20,
  parameter int CNT_W     = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [REC_W-1:0] in_record,
  input logic             match_valid,
  input logic [KEY_W-1:0] match_key,
  input logic [CNT_W-1:0] drop_count
);

  logic [PRICE_W-1:0] price;
  logic [KEY_W-1:0]   key;
  assign price = in_record[PRICE_LSB +: PRICE_W];
  assign key   = in_record[KEY_W-1:0];

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!match_valid && (drop_count == '0)));

  // R4
  match_src_chk: assert property (@(posedge clk) disable iff (rst)
    match_valid |-> ($past(in_valid, 2) && ($past(price, 2) < PRICE_W'(PIVOT))
                     && (match_key == $past(key, 2))));

  // R9
  drop_step_chk: assert property (@(posedge clk) disable iff (rst)
    (drop_count != $past(drop_count)) |->
      ((drop_count == CNT_W'($past(drop_count) + 1'b1)) && $past(in_valid, 2)
       && ($past(price, 2) == PRICE_W'(PIVOT))));

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(in_valid, 2) |-> (!match_valid && $stable(drop_count)));

  // R8
  match_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (match_valid && $past(match_valid)) |-> (match_key != $past(match_key)));

endmodule

bind keyed_pattern_detector kpd_checker #(
  .REC_W(REC_W), .KEY_W(KEY_W), .PRICE_W(PRICE_W),
  .PRICE_LSB(PRICE_LSB), .PIVOT(PIVOT), .CNT_W(CNT_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .in_record   (in_record),
  .match_valid (match_valid),
  .match_key   (match_key),
  .drop_count  (drop_count)
);

// File: tb/keyed_pattern_detector_bench.sv
module keyed_pattern_detector_bench;

  localparam int REC_W     = 128;
  localparam int KEY_W     = 32;
  localparam int PRICE_W   = 32;
  localparam int PRICE_LSB = 32;
  localparam int PIVOT     = 20;
  localparam int IDX_W     = 4;
  localparam int CNT_W     = 16;
  localparam int SLOTS     = 1 << IDX_W;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             in_valid = 1'b0;
  logic [REC_W-1:0] in_record = '0;
  logic             in_ready;
  logic             match_valid;
  logic [KEY_W-1:0] match_key;
  logic [CNT_W-1:0] drop_count;

  always #4 clk = ~clk;

  keyed_pattern_detector #(
    .REC_W(REC_W), .KEY_W(KEY_W), .PRICE_W(PRICE_W), .PRICE_LSB(PRICE_LSB),
    .PIVOT(PIVOT), .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) u_keyed_pattern_detector (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_record(in_record), .match_valid(match_valid), .match_key(match_key),
    .drop_count(drop_count)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Reference model: which key owns each slot, and the drop total.
  bit               m_live [SLOTS];
  logic [KEY_W-1:0] m_tag  [SLOTS];
  int               m_drops = 0;

  // Two-deep expectation pipe: [1] is due at the current sample.
  bit               pv [2];
  logic [KEY_W-1:0] pk [2];
  int               pd [2];
  string            pt [2];

  localparam logic [KEY_W-1:0] K1 = 32'h0A00_0001;
  localparam logic [KEY_W-1:0] K2 = 32'h0A00_0002;
  localparam logic [KEY_W-1:0] K3 = 32'h0A00_0003;
  localparam logic [KEY_W-1:0] K4 = 32'h0A00_0004;
  localparam logic [KEY_W-1:0] KX = 32'h0000_0011;  // slot 0
  localparam logic [KEY_W-1:0] KY = 32'h0000_0022;  // slot 0

  function automatic int slot_of(logic [KEY_W-1:0] k);
    int r = 0;
    for (int i = 0; i < KEY_W; i += IDX_W) r = r ^ int'((k >> i) & (SLOTS - 1));
    return r;
  endfunction

  task automatic check(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step(bit v, logic [KEY_W-1:0] key, logic [PRICE_W-1:0] price, string tag);
    bit mv = 0;
    int s;
    @(negedge clk);
    check(pt[1], "match_valid", match_valid, pv[1]);
    if (pv[1]) check(pt[1], "match_key", match_key, pk[1]);
    check(pt[1], "drop_count", drop_count, pd[1] & ((1 << CNT_W) - 1));
    check("R2", "in_ready", in_ready, 1);
    in_valid  = v;
    in_record = {$urandom(), $urandom(), $urandom(), $urandom()};
    in_record[KEY_W-1:0] = key;
    in_record[PRICE_LSB +: PRICE_W] = price;
    if (v) begin
      s = slot_of(key);
      if (price == PIVOT) begin
        if (!m_live[s] || m_tag[s] == key) begin
          m_live[s] = 1;
          m_tag[s]  = key;
        end else begin
          m_drops++;
        end
      end else if (m_live[s] && m_tag[s] == key && price < PIVOT) begin
        mv = 1;
        m_live[s] = 0;
      end
    end
    pv[1] = pv[0]; pk[1] = pk[0]; pd[1] = pd[0]; pt[1] = pt[0];
    pv[0] = mv;    pk[0] = key;   pd[0] = m_drops; pt[0] = tag;
  endtask

  initial begin
    for (int i = 0; i < SLOTS; i++) begin m_live[i] = 0; m_tag[i] = '0; end
    for (int i = 0; i < 2; i++) begin pv[i] = 0; pk[i] = '0; pd[i] = 0; pt[i] = "R1"; end
    repeat (3) @(negedge clk);
    check("R1", "match_valid in reset", match_valid, 0);
    check("R1", "drop_count in reset", drop_count, 0);
    rst = 1'b0;
    step(0, K1, 20, "R1");
    step(0, K1, 19, "R1");
    // R3 / R4: opener, two extenders (one all-ones), closer
    step(1, K1, 20, "R3");
    step(1, K1, 21, "R3");
    step(1, K1, 32'hFFFF_FFFF, "R3");
    step(1, K1, 19, "R4");
    // R4 with zero extenders
    step(1, K2, 20, "R4");
    step(1, K2, 0, "R4");
    // R6: no open candidate
    step(1, K1, 0, "R6");
    step(1, K1, 25, "R6");
    step(1, K1, 5, "R6");
    // R5: restart on opener
    step(1, K1, 20, "R5");
    step(1, K1, 40, "R5");
    step(1, K1, 20, "R5");
    step(1, K1, 3, "R5");
    step(1, K1, 20, "R5");
    step(1, K1, 20, "R5");
    step(1, K1, 19, "R5");
    // R7: interleaved partitions
    step(1, K1, 20, "R7");
    step(1, K2, 20, "R7");
    step(1, K3, 20, "R7");
    step(1, K2, 99, "R7");
    step(1, K1, 1, "R7");
    step(1, K3, 2, "R7");
    step(1, K2, 7, "R7");
    // R11: invalid cycles carry live-looking records
    step(1, K4, 20, "R11");
    step(0, K4, 19, "R11");
    step(0, K3, 20, "R11");
    step(1, K3, 19, "R11");
    step(1, K4, 19, "R11");
    // R9: slot conflict
    step(1, KX, 20, "R9");
    step(1, KY, 20, "R9");
    step(1, KY, 19, "R9");
    step(1, KX, 21, "R9");
    step(1, KX, 19, "R9");
    // R10 / R8: free then reclaim on the next cycle
    step(1, KX, 20, "R10");
    step(1, KX, 19, "R10");
    step(1, KY, 20, "R10");
    step(1, KY, 19, "R10");
    step(1, KY, 20, "R8");
    step(1, KY, 30, "R8");
    step(1, KY, 19, "R8");
    step(1, KY, 20, "R8");
    step(1, KY, 18, "R8");
    // Mixed random traffic
    for (int n = 0; n < 4000; n++) begin
      logic [KEY_W-1:0] k;
      logic [PRICE_W-1:0] p;
      int r = $urandom_range(0, 5);
      case (r)
        0: k = K1; 1: k = K2; 2: k = KX; 3: k = KY; 4: k = K3; default: k = K4;
      endcase
      r = $urandom_range(0, 7);
      case (r)
        0, 1: p = 20; 2, 3: p = 19; 4: p = 21;
        5: p = 32'hFFFF_FFFF; 6: p = 0; default: p = $urandom();
      endcase
      step($urandom_range(0, 4) != 0, k, p, "R7");
    end
    step(0, K1, 0, "R11");
    step(0, K1, 0, "R11");
    step(0, K1, 0, "R11");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule